// File: doc/BRIEF.md
# NAND Chunk Parity Code Generator

This block sits beside the byte path of a NAND flash controller. It builds a single-error-correcting parity code over each 256-byte slice of a page as the bytes stream past. Each byte adds its row parity to line-parity bits selected by its position in the chunk. Its bits add column parity grouped by bit index. After the last byte of a chunk, the finished code is latched into a 32-bit code word. A one-cycle done pulse fires, and the next chunk starts again from zero.

Alongside the raw code, the block presents the code in the three-byte form that is written to the spare area. Software or a DMA engine copies these bytes into the out-of-band region, and on a later read the stored bytes are compared with a freshly computed code. A hold option lets the stream stall after each chunk until the code has been collected. With the hold option off, the code is read while the next chunk keeps flowing.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, code_word is 0, chunk_done is 0, in_ready is 1, and every spare_bytes lane is 8'hFF.
- R2: The raw code is 22 bits. Bits 0..5 are column parities. Bit 2j holds the XOR of data bits whose index has bit j clear, and bit 2j+1 holds the XOR of data bits whose index has bit j set, for j = 0, 1, 2. For each address bit k = 0..7, bit 6+2k is the XOR of the row parities of bytes whose chunk position has bit k clear, and bit 7+2k is the same for bytes whose position has bit k set. Bits 31..22 of code_word are 0.
- R3: chunk_done is high for exactly one cycle: the cycle after the 256th counted byte is transferred. code_word takes the new code in that same cycle, and the next chunk accumulates from zero.
- R4: A clear pulse returns the accumulation and the byte position to the start. A byte transferred in the same cycle as clear is discarded, and code_word keeps its value.
- R5: code_word changes only on chunk completion and holds its value across the following chunk.
- R6: A byte transferred while ecc_en is low is neither counted nor accumulated.
- R7: While hold_on_done is low, in_ready stays high.
- R8: If hold_on_done is high when a chunk completes, in_ready is low from the done cycle until code_ack is pulsed. in_ready is high again in the cycle after the pulse.
- R9: spare_bytes lane i (bits 8i+7..8i) holds the byte stored at spare offset i. With s = ~(code << 2) masked to 24 bits, offset 0 is s[23:16], offset 1 is s[15:8] and offset 2 is s[7:0].
- R10: A byte transfers only in a cycle with in_valid and in_ready both high. A byte held on in_data while in_ready is low is taken, once, after the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered on in_data |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Stream byte |
| ecc_en | input | 1 | Count and accumulate transferred bytes |
| clear | input | 1 | Restart the current chunk from zero |
| hold_on_done | input | 1 | Stall the stream after each completed chunk |
| code_ack | input | 1 | Code collected; release a hold stall |
| chunk_done | output | 1 | One-cycle pulse when a chunk's code is latched |
| code_word | output | 32 | Last completed raw code, zero-extended |
| spare_bytes | output | 24 | Spare-area bytes, lane i is offset i |

## Verification
A byte is transferred at the rising edge where in_valid and in_ready are both high. The code of a chunk's last byte is visible on code_word and spare_bytes right after that edge, together with chunk_done. The bench drives inputs on falling edges and samples one falling edge after the final transfer, where it expects chunk_done high and the new code. It samples again one cycle later and expects chunk_done low. in_ready is combinational from a register, so the bench checks it on the falling edge of the done cycle, and on the falling edge after the code_ack pulse.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // Column groups: for data bit index weight 2^j, mask of bits whose index has bit j == sel
  function automatic logic [7:0] col_mask(input int j, input bit sel);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) begin
      m[i] = (((i >> j) & 1) == int'(sel));
    end
    return m;
  endfunction

  function automatic int code_width(input int addr_w, input int col_w);
    return 2 * addr_w + 2 * col_w;
  endfunction

  function automatic int spare_lanes(input int code_w);
    return (code_w + 2 + 7) / 8;
  endfunction

  typedef struct packed {
    logic waiting;
    logic done;
  } chunk_flags_t;

endpackage

// File: rtl/nand_ecc_byte_terms.sv
module nand_ecc_byte_terms
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int COL_W  = $clog2(DATA_W),
  parameter int CODE_W = code_width(ADDR_W, COL_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] pos,
  output logic [CODE_W-1:0] term
);
  localparam int LINE_BASE = 2 * COL_W;

  logic row_par;
  assign row_par = ^data;

  genvar j, k;
  generate
    for (j = 0; j < COL_W; j++) begin : g_col
      localparam logic [7:0] M_LO = col_mask(j, 1'b0);
      localparam logic [7:0] M_HI = col_mask(j, 1'b1);
      assign term[2*j]   = ^(data & M_LO[DATA_W-1:0]);
      assign term[2*j+1] = ^(data & M_HI[DATA_W-1:0]);
    end
    for (k = 0; k < ADDR_W; k++) begin : g_line
      assign term[LINE_BASE + 2*k]     = row_par & ~pos[k];
      assign term[LINE_BASE + 2*k + 1] = row_par &  pos[k];
    end
  endgenerate
endmodule

// File: rtl/nand_ecc_chunk_ctrl.sv
module nand_ecc_chunk_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int ADDR_W      = $clog2(CHUNK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clear,
  input  logic              hold_on_done,
  input  logic              code_ack,
  output logic [ADDR_W-1:0] pos,
  output logic              last,
  output logic              done,
  output logic              waiting
);
  localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(CHUNK_BYTES - 1);

  chunk_flags_t flags_q, flags_d;
  logic [ADDR_W-1:0] pos_q;

  assign last = take && (pos_q == LAST_POS);

  always_comb begin
    flags_d = flags_q;
    flags_d.done = last;
    if (clear || code_ack) flags_d.waiting = 1'b0;
    if (last && hold_on_done) flags_d.waiting = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
      if (clear)      pos_q <= '0;
      else if (last)  pos_q <= '0;
      else if (take)  pos_q <= pos_q + 1'b1;
    end
  end

  assign pos     = pos_q;
  assign done    = flags_q.done;
  assign waiting = flags_q.waiting;
endmodule

// File: rtl/nand_ecc_spare_pack.sv
module nand_ecc_spare_pack
  import nand_ecc_pkg::*;
#(
  parameter int CODE_W = 22,
  parameter int LANES  = spare_lanes(CODE_W)
) (
  input  logic [CODE_W-1:0]  code,
  output logic [LANES*8-1:0] lanes
);
  localparam int SW = LANES * 8;

  logic [SW-1:0] shifted;
  assign shifted = ~(SW'(code) << 2);

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      // offset i takes the byte counted from the top of the shifted word
      assign lanes[8*i +: 8] = shifted[8*(LANES-1-i) +: 8];
    end
  endgenerate
endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int DATA_W      = 8,
  parameter int OUT_W       = 32,
  parameter int SPARE_W     = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               ecc_en,
  input  logic               clear,
  input  logic               hold_on_done,
  input  logic               code_ack,
  output logic               chunk_done,
  output logic [OUT_W-1:0]   code_word,
  output logic [SPARE_W-1:0] spare_bytes
);
  localparam int ADDR_W = $clog2(CHUNK_BYTES);
  localparam int COL_W  = $clog2(DATA_W);
  localparam int CODE_W = code_width(ADDR_W, COL_W);
  localparam int LANES  = spare_lanes(CODE_W);

  logic              waiting, take, last;
  logic [ADDR_W-1:0] pos;
  logic [CODE_W-1:0] term, acc_q, code_q, acc_next;

  assign in_ready = !waiting;
  assign take     = in_valid && in_ready && ecc_en && !clear;

  nand_ecc_chunk_ctrl #(.CHUNK_BYTES(CHUNK_BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take), .clear(clear),
    .hold_on_done(hold_on_done), .code_ack(code_ack),
    .pos(pos), .last(last), .done(chunk_done), .waiting(waiting)
  );

  nand_ecc_byte_terms #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .CODE_W(CODE_W)) u_terms (
    .data(in_data), .pos(pos), .term(term)
  );

  assign acc_next = acc_q ^ term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      code_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (last) begin
      acc_q  <= '0;
      code_q <= acc_next;
    end else if (take) begin
      acc_q <= acc_next;
    end
  end

  assign code_word = OUT_W'(code_q);

  logic [LANES*8-1:0] lanes;
  nand_ecc_spare_pack #(.CODE_W(CODE_W), .LANES(LANES)) u_pack (
    .code(code_q), .lanes(lanes)
  );
  assign spare_bytes = SPARE_W'(lanes);
endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        clear,
  input logic        hold_on_done,
  input logic        code_ack,
  input logic        chunk_done,
  input logic [31:0] code_word
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> !chunk_done); // R3
  AST_CLEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !chunk_done); // R4
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !chunk_done |-> $stable(code_word)); // R5
  AST_FREE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_on_done && in_ready) |=> in_ready); // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done && $past(hold_on_done)) |-> !in_ready); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    code_ack |=> in_ready); // R8
endmodule

bind nand_page_ecc nand_page_ecc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .clear(clear),
  .hold_on_done(hold_on_done), .code_ack(code_ack),
  .chunk_done(chunk_done), .code_word(code_word)
);

// File: tb/nand_page_ecc_bench.sv
module nand_page_ecc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, ecc_en = 1'b1, clear = 1'b0;
  logic        hold_on_done = 1'b0, code_ack = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, chunk_done;
  logic [31:0] code_word;
  logic [23:0] spare_bytes;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  mem [256];
  logic [31:0] prev_code;

  always #5 clk = ~clk;

  nand_page_ecc u_nand_page_ecc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ecc_en(ecc_en), .clear(clear),
    .hold_on_done(hold_on_done), .code_ack(code_ack),
    .chunk_done(chunk_done), .code_word(code_word), .spare_bytes(spare_bytes)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_code();
    logic [21:0] c = '0;
    for (int a = 0; a < 256; a++) begin
      logic p = ^mem[a];
      for (int j = 0; j < 3; j++)
        for (int b = 0; b < 8; b++)
          if (((b >> j) & 1) == 1) c[2*j+1] ^= mem[a][b];
          else                     c[2*j]   ^= mem[a][b];
      for (int k = 0; k < 8; k++)
        if (((a >> k) & 1) == 1) c[7+2*k] ^= p;
        else                     c[6+2*k] ^= p;
    end
    return {10'd0, c};
  endfunction

  function automatic logic [23:0] ref_spare(input logic [31:0] c);
    logic [23:0] s = ~({c[21:0], 2'b00});
    return {s[7:0], s[15:8], s[23:16]};
  endfunction

  task automatic push(input logic [7:0] d, input logic en);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; ecc_en = en;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_done(input string tag);
    logic [31:0] e = ref_code();
    @(negedge clk);
    in_valid = 1'b0;
    chk(chunk_done == 1'b1, {tag, " R3 done pulse"}, {31'd0, chunk_done}, 32'd1);
    chk(code_word == e, {tag, " R2 code"}, code_word, e);
    chk(spare_bytes == ref_spare(e), {tag, " R9 spare"}, {8'd0, spare_bytes}, {8'd0, ref_spare(e)});
    if (!hold_on_done) chk(in_ready == 1'b1, {tag, " R7 ready"}, {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    chk(chunk_done == 1'b0, {tag, " R3 single cycle"}, {31'd0, chunk_done}, 32'd0);
  endtask

  // fill mem (optionally), stream it with random gaps and ignored bytes
  task automatic run_chunk(input bit rnd, input bit gaps, input bit junk, input string tag);
    for (int i = 0; i < 256; i++) if (rnd) mem[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) begin
      if (gaps && ($urandom % 4 == 0)) idle();
      if (junk && ($urandom % 5 == 0)) push(8'($urandom | 1), 1'b0); // R6 ignored byte
      push(mem[i], 1'b1);
    end
    check_done(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #12;
    @(negedge clk);
    chk(code_word == 32'd0, "R1 code reset", code_word, 32'd0);
    chk(chunk_done == 1'b0, "R1 done reset", {31'd0, chunk_done}, 32'd0);
    chk(in_ready == 1'b1, "R1 ready reset", {31'd0, in_ready}, 32'd1);
    chk(spare_bytes == 24'hFFFFFF, "R1 spare reset", {8'd0, spare_bytes}, 32'h00FFFFFF);
    rst_n = 1'b1;

    // directed: single set bit at position 0
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0] = 8'h01;
    run_chunk(1'b0, 1'b0, 1'b0, "single");
    chk(code_word == 32'h0015_5555, "R2 directed layout", code_word, 32'h0015_5555);

    // directed: all 0xFF, last position only flipped
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    mem[255] = 8'h80;
    run_chunk(1'b0, 1'b1, 1'b0, "top");

    // random chunks, back to back, with gaps, with ignored bytes
    run_chunk(1'b1, 1'b0, 1'b0, "rand0");
    run_chunk(1'b1, 1'b1, 1'b0, "rand1");
    run_chunk(1'b1, 1'b1, 1'b1, "R6 rand2");

    // clear mid-chunk, code held across partial chunk
    prev_code = code_word;
    for (int i = 0; i < 100; i++) push(8'($urandom), 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(code_word == prev_code, "R5 held mid chunk", code_word, prev_code);
    in_valid = 1'b1; in_data = 8'hA5; clear = 1'b1; // same-cycle byte discarded
    @(negedge clk);
    clear = 1'b0; in_valid = 1'b0;
    chk(code_word == prev_code, "R4 clear keeps code", code_word, prev_code);
    chk(chunk_done == 1'b0, "R4 no done after clear", {31'd0, chunk_done}, 32'd0);
    run_chunk(1'b1, 1'b1, 1'b0, "R4 after clear");

    // hold mode
    hold_on_done = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) push(mem[i], 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(chunk_done == 1'b1, "R8 done in hold", {31'd0, chunk_done}, 32'd1);
    chk(in_ready == 1'b0, "R8 stall at done", {31'd0, in_ready}, 32'd0);
    chk(code_word == ref_code(), "R2 hold code", code_word, ref_code());
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    in_valid = 1'b1; in_data = mem[0]; ecc_en = 1'b1; // offered while stalled
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R10 stalled", {31'd0, in_ready}, 32'd0);
    end
    code_ack = 1'b1;
    @(negedge clk);
    code_ack = 1'b0;
    chk(in_ready == 1'b1, "R8 released", {31'd0, in_ready}, 32'd1);
    @(posedge clk); // mem[0] transfers here, once
    for (int i = 1; i < 256; i++) push(mem[i], 1'b1);
    check_done("R10 after stall");
    hold_on_done = 1'b0;
    code_ack = 1'b1;
    @(negedge clk);
    code_ack = 1'b0;

    run_chunk(1'b1, 1'b1, 1'b1, "final");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule